// File: doc/BRIEF.md
# Data breakpoint match unit

This block is a debug data-breakpoint unit. It holds a configurable number of channels, from 1 to 15. Each channel has an address register and an enable bit. On every valid data access from the processor, each enabled channel compares its stored address with the full access address. Loads and stores are treated the same way. When a channel hits, it raises a one-cycle match pulse and sets its bit in a shared status word.

Status bits are sticky. Hardware sets them, and only software clears them, by writing zero. Reset leaves them untouched, so debug software clears them before use. The status word also carries read-only fields: the number of implemented channels, and two flags stating that loads and stores are compared on address only.

Software reaches the registers over a simple memory-mapped debug bus. The status word is at offset 0x2000. The enable register is at 0x2008. Channel n's address register is at 0x2100 + 0x100*n.

Top module: `dbrk_match_unit`

## Requirements
- R1: A status read returns bit 29 = 1 and bit 28 = 1 (stores and loads are compared on address only). Bits 27:24 hold the channel count NUM_CH. Bits 31, 30 and 23:15 read as zero.
- R2: Channel n hits when all three of these hold in the same cycle: accValid is 1, accAddr equals its address register, and enable bit n is 1. At the next clock edge, matchPulse[n] goes to 1 and status bit n is set. matchPulse[n] stays high for exactly that one cycle.
- R3: A channel does not hit in any of these cases: its enable bit is 0, the address differs in any bit, or accValid is 0.
- R4: A set status bit stays set until software clears it.
- R5: Writing the status word clears each implemented status bit written as 0. Bits written as 1 keep their value.
- R6: If a clearing write and a new hit on the same channel occur in the same cycle, the status bit ends up set.
- R7: Status bits NUM_CH..14 read as zero and cannot be changed by writes.
- R8: Reset clears the enable register. It does not change the status bits or the address registers.
- R9: Channel n's address register at offset 0x2100 + 0x100*n is read/write. The enable register at offset 0x2008 holds enable bit n at bit n; its other bits read as zero.
- R10: Reads of any other offset return zero. Writes to other offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Debug register access valid |
| regWrite | input | 1 | 1 = write, 0 = read |
| regOffset | input | 16 | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational during a read access |
| accValid | input | 1 | Processor data access (load or store) valid |
| accAddr | input | ADDR_W | Data access address |
| matchPulse | output | NUM_CH | One-cycle hit pulse per channel |

## Verification
Accesses are driven in several ways:
- With the channel disabled, and then enabled, which tells the enable gate apart from the comparator.
- With addresses that differ from a stored one only in a low bit, which separates full-width comparison from partial comparison.
- With addresses that hit different channels one after another, which shows each status bit accumulating independently.

Status writes are applied with patterns of all ones, a single zero, and zeros confined to implemented bits. These show that ones preserve bits, that zeros clear only their own bit, and that bits above the channel count are inert. A clear issued in the same cycle as a hit, and a reset applied while a status bit is set, show the priority of a hit over a clear and the status bits' immunity to reset.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
  localparam int MAX_CH = 15;
  localparam int REG_W  = 32;
  localparam int OFF_W  = 16;

  localparam logic [OFF_W-1:0] STS_OFF    = 16'h2000;
  localparam logic [OFF_W-1:0] EN_OFF     = 16'h2008;
  localparam int               ADR_BASE   = 'h2100;
  localparam int               ADR_STRIDE = 'h0100;

  typedef enum logic [1:0] {RD_NONE, RD_STS, RD_EN, RD_ADR} rdKind_e;

  typedef struct packed {
    logic              stsWr;
    logic              enWr;
    logic [MAX_CH-1:0] adrWr;
    rdKind_e           rdKind;
    logic [3:0]        rdIdx;
  } regStrb_t;
endpackage

// File: rtl/dbrk_ctrl.sv
module dbrk_ctrl
  import dbrk_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWrite,
  input  logic [OFF_W-1:0] regOffset,
  output regStrb_t         strb
);

  always_comb begin
    strb        = '0;
    strb.rdKind = RD_NONE;
    if (regSel) begin
      if (regOffset == STS_OFF) begin
        strb.stsWr = regWrite;
        if (!regWrite) strb.rdKind = RD_STS;
      end else if (regOffset == EN_OFF) begin
        strb.enWr = regWrite;
        if (!regWrite) strb.rdKind = RD_EN;
      end else begin
        for (int n = 0; n < NUM_CH; n++) begin
          if (regOffset == OFF_W'(ADR_BASE + n * ADR_STRIDE)) begin
            strb.adrWr[n] = regWrite;
            if (!regWrite) begin
              strb.rdKind = RD_ADR;
              strb.rdIdx  = 4'(n);
            end
          end
        end
      end
    end
  end

  // R9: at most one register is the target of a write
  p_one_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stsWr, strb.enWr, strb.adrWr}));

  // R10: a read selection never coincides with a write
  p_rd_not_wr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdKind != RD_NONE) |-> (regSel && !regWrite));

endmodule

// File: rtl/dbrk_datapath.sv
module dbrk_datapath
  import dbrk_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [NUM_CH-1:0] matchPulse,
  output logic [REG_W-1:0]  regRdata
);

  logic [ADDR_W-1:0] adrQ [NUM_CH];
  logic [NUM_CH-1:0] enQ;
  logic [NUM_CH-1:0] stsQ;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] pulseQ;
  logic [ADDR_W-1:0] adrSel;
  logic [MAX_CH-1:0] stsWide;
  logic              unusedStrb;

  assign unusedStrb = ^strb.adrWr;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    always_ff @(posedge clk) begin
      if (strb.adrWr[n]) adrQ[n] <= regWdata[ADDR_W-1:0];
    end
    assign hit[n] = accValid && enQ[n] && (accAddr == adrQ[n]);

    // R2: a hit raises the pulse and the status bit on the next edge
    p_hit_flags_r2: assert property (@(posedge clk) disable iff (!rstN)
      hit[n] |=> (stsQ[n] && matchPulse[n]));
    // R2: status bit only rises on a hit
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!stsQ[n] && !hit[n]) |=> !stsQ[n]);
    // R3: no pulse without a hit
    p_no_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
      !hit[n] |=> !matchPulse[n]);
    // R4: status stays set unless a zero is written
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
      (stsQ[n] && !(strb.stsWr && !regWdata[n])) |=> stsQ[n]);
    // R5: zero written without a hit clears the bit
    p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strb.stsWr && !regWdata[n] && !hit[n]) |=> !stsQ[n]);
    // R6: hit beats a simultaneous clear
    p_match_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.stsWr && !regWdata[n] && hit[n]) |=> stsQ[n]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          enQ <= '0;
    else if (strb.enWr) enQ <= regWdata[NUM_CH-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.stsWr) stsQ <= (stsQ & regWdata[NUM_CH-1:0]) | hit;
    else            stsQ <= stsQ | hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseQ <= '0;
    else       pulseQ <= hit;
  end
  assign matchPulse = pulseQ;

  always_comb begin
    adrSel = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (strb.rdIdx == 4'(n)) adrSel = adrQ[n];
    end
  end

  assign stsWide = MAX_CH'(stsQ);

  always_comb begin
    unique case (strb.rdKind)
      RD_STS:  regRdata = {2'b00, 2'b11, 4'(NUM_CH), 9'b0, stsWide};
      RD_EN:   regRdata = REG_W'(enQ);
      RD_ADR:  regRdata = REG_W'(adrSel);
      default: regRdata = '0;
    endcase
  end

  // R1: fixed fields of the status word
  p_sts_fields_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdKind == RD_STS) |->
      (regRdata[31:28] == 4'b0011 && regRdata[27:24] == 4'(NUM_CH) &&
       regRdata[23:15] == '0));
  // R7: unimplemented status bits read zero
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdKind == RD_STS) |-> ((regRdata[14:0] >> NUM_CH) == '0));
  // R10: unmapped reads return zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdKind == RD_NONE) |-> (regRdata == '0));

endmodule

// File: rtl/dbrk_match_unit.sv
module dbrk_match_unit
  import dbrk_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [15:0]       regOffset,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [NUM_CH-1:0] matchPulse
);

  regStrb_t strb;

  initial begin
    assert (NUM_CH >= 1 && NUM_CH <= MAX_CH && ADDR_W >= 1 && ADDR_W <= REG_W);
  end

  dbrk_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regSel    (regSel),
    .regWrite  (regWrite),
    .regOffset (regOffset),
    .strb      (strb)
  );

  dbrk_datapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regWdata   (regWdata),
    .accValid   (accValid),
    .accAddr    (accAddr),
    .matchPulse (matchPulse),
    .regRdata   (regRdata)
  );

endmodule

// File: tb/dbrk_match_unit_bench.sv
module dbrk_match_unit_bench;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 32;
  localparam int NV     = 31;
  localparam logic [1:0] K_W = 2'd0, K_R = 2'd1, K_A = 2'd2;

  // {req, kind, offset, data, expected}
  localparam logic [85:0] VEC [NV] = '{
    {4'd5,  K_W, 16'h2000, 32'h0000_0000, 32'h0},          // R5 clear all
    {4'd1,  K_R, 16'h2000, 32'h0,         32'h3400_0000},  // R1 fields
    {4'd9,  K_W, 16'h2100, 32'h1000_0040, 32'h0},
    {4'd9,  K_W, 16'h2200, 32'h1000_0080, 32'h0},
    {4'd9,  K_W, 16'h2300, 32'hDEAD_BEE0, 32'h0},
    {4'd9,  K_W, 16'h2400, 32'h0000_0004, 32'h0},
    {4'd9,  K_R, 16'h2200, 32'h0,         32'h1000_0080},  // R9
    {4'd9,  K_R, 16'h2400, 32'h0,         32'h0000_0004},
    {4'd3,  K_A, 16'h0,    32'h1000_0040, 32'h0},          // R3 disabled
    {4'd9,  K_W, 16'h2008, 32'h0000_FFFF, 32'h0},
    {4'd9,  K_R, 16'h2008, 32'h0,         32'h0000_000F},
    {4'd2,  K_A, 16'h0,    32'h1000_0040, 32'h1},          // R2 ch0
    {4'd2,  K_R, 16'h2000, 32'h0,         32'h3400_0001},
    {4'd3,  K_A, 16'h0,    32'h1000_0044, 32'h0},          // R3 near miss
    {4'd3,  K_A, 16'h0,    32'hDEAD_BEE1, 32'h0},
    {4'd2,  K_A, 16'h0,    32'hDEAD_BEE0, 32'h4},          // R2 ch2
    {4'd2,  K_A, 16'h0,    32'h0000_0004, 32'h8},          // R2 ch3
    {4'd4,  K_R, 16'h2000, 32'h0,         32'h3400_000D},  // R4 sticky
    {4'd5,  K_W, 16'h2000, 32'hFFFF_FFFF, 32'h0},
    {4'd5,  K_R, 16'h2000, 32'h0,         32'h3400_000D},  // R5 ones keep
    {4'd5,  K_W, 16'h2000, 32'hFFFF_FFFB, 32'h0},
    {4'd5,  K_R, 16'h2000, 32'h0,         32'h3400_0009},  // R5 one zero
    {4'd7,  K_W, 16'h2000, 32'h0000_7FF0, 32'h0},
    {4'd7,  K_R, 16'h2000, 32'h0,         32'h3400_0000},  // R7
    {4'd10, K_W, 16'h2004, 32'hFFFF_FFFF, 32'h0},
    {4'd10, K_R, 16'h2004, 32'h0,         32'h0},          // R10
    {4'd10, K_W, 16'h2500, 32'h1234_5678, 32'h0},
    {4'd10, K_R, 16'h2500, 32'h0,         32'h0},
    {4'd10, K_R, 16'h2008, 32'h0,         32'h0000_000F},
    {4'd10, K_R, 16'h2100, 32'h0,         32'h1000_0040},
    {4'd10, K_R, 16'h1FFC, 32'h0,         32'h0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regSel = 1'b0;
  logic              regWrite = 1'b0;
  logic [15:0]       regOffset = '0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic              accValid = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic [NUM_CH-1:0] matchPulse;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;

  dbrk_match_unit #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dbrk_match_unit (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regOffset(regOffset), .regWdata(regWdata), .regRdata(regRdata),
    .accValid(accValid), .accAddr(accAddr), .matchPulse(matchPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [15:0] off, input logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regOffset = off; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [15:0] off, output logic [31:0] q);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b0; regOffset = off;
    #2 q = regRdata;
    regSel = 1'b0;
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, output logic [NUM_CH-1:0] p);
    @(negedge clk);
    accValid = 1'b1; accAddr = a;
    @(negedge clk);
    accValid = 1'b0;
    #1 p = matchPulse;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0]       q;
    logic [NUM_CH-1:0] p;
    logic [85:0]       v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state: R8 enables cleared, R1 fixed fields
    check("R8 reset pulse", 32'(matchPulse), 32'h0);
    regRd(16'h2008, q);
    check("R8 reset enable", q, 32'h0);
    regRd(16'h2000, q);
    check("R1 reset fields", q & 32'hFFFF_8000, 32'h3400_0000);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      case (v[81:80])
        K_W: regWr(v[79:64], v[63:32]);
        K_R: begin
          regRd(v[79:64], q);
          check($sformatf("R%0d vec%0d", v[85:82], i), q, v[31:0]);
        end
        default: begin
          access(v[63:32], p);
          check($sformatf("R%0d vec%0d", v[85:82], i), 32'(p), v[31:0]);
        end
      endcase
    end

    // R2: pulse lasts one cycle only
    access(32'h1000_0080, p);
    check("R2 pulse", 32'(p), 32'h2);
    @(negedge clk); #1;
    check("R2 pulse one cycle", 32'(matchPulse), 32'h0);

    // R6: clear and hit in the same cycle
    access(32'h1000_0040, p);
    regRd(16'h2000, q);
    check("R6 setup", q, 32'h3400_0003);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regOffset = 16'h2000; regWdata = 32'h0;
    accValid = 1'b1; accAddr = 32'h1000_0040;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0; accValid = 1'b0;
    #1 check("R6 pulse", 32'(matchPulse), 32'h1);
    regRd(16'h2000, q);
    check("R6 match wins", q, 32'h3400_0001);

    // R8: reset keeps status and addresses, clears enables
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    regRd(16'h2008, q);
    check("R8 enable cleared", q, 32'h0);
    regRd(16'h2000, q);
    check("R8 status kept", q, 32'h3400_0001);
    regRd(16'h2100, q);
    check("R8 address kept", q, 32'h1000_0040);
    access(32'h1000_0040, p);
    check("R8 no hit after reset", 32'(p), 32'h0);

    finish_run();
  end
endmodule